// File: doc/BRIEF.md
# Exception Entry and Processor Mode Controller

This block sequences exception entry and exception return for a 32-bit RISC core. It owns the current status word (condition flags, interrupt masks, the compact-instruction state bit and the mode field) and one saved status word for each of the five exception modes. Requests come in from the rest of the core and from outside: reset, undefined instruction, software interrupt, instruction-fetch abort, data abort, normal interrupt and fast interrupt. When it takes one, it picks the winner and computes the handler vector, the new mode and the link value. It updates the masks and banks the old status, all in one clock.

The core's fetch unit uses the one-cycle PC-load strobe and vector to redirect fetch. The register file uses the link-write strobe, link value and target mode to write the banked link register. The handler returns by pulsing the return input, which restores the banked status of the current mode. Privileged software can also rewrite the status word through a write port, which checks the mode field.

Top module: `xcpt_mode_ctrl`

## Requirements
- R1: While reset is high, the status word is 0x000000D3 (supervisor mode 5'b10011, I bit 7 and F bit 6 set, T bit 5 clear, flags 31:28 zero), `pc_load` is 1 with `pc_target` 0, and `lr_wr` is 0.
- R2: An entry drives `pc_target` and the new mode as follows: undefined 0x04 / 5'b11011, software interrupt 0x08 / 5'b10011, fetch abort 0x0C / 5'b10111, data abort 0x10 / 5'b10111, IRQ 0x18 / 5'b10010, FIQ 0x1C / 5'b10001. The vector 0x14 is never used.
- R3: On entry `lr_value` is `fault_addr`+4 for undefined, software interrupt and fetch abort, `fault_addr`+8 for data abort, and `pc_now`-4 for IRQ and FIQ. `lr_mode` carries the target mode.
- R4: Every entry sets I (bit 7) and clears T (bit 5). FIQ entry also sets F (bit 6); other entries keep F. Bits 31:8 are kept.
- R5: Every entry copies the previous status word into the saved word of the target mode. `cur_saved` shows the saved word of the current mode and reads 0 in user (5'b10000) and system (5'b11111) mode.
- R6: IRQ is ignored while I is set and FIQ is ignored while F is set.
- R7: Simultaneous requests are resolved highest first as reset, data abort, FIQ, IRQ, fetch abort, undefined, software interrupt.
- R8: `ret_req` in a banked mode copies that mode's saved word into the status word, restoring flags, masks, T and mode. In user or system mode it has no effect.
- R9: A status write (`st_wr`) outside user mode takes all bits of `st_wdata`. If its mode field is not one of the seven legal encodings, the mode is kept, the other bits are taken and `illegal_mode` pulses for one cycle. A return with an illegal saved mode is treated the same way.
- R10: In user mode a status write changes only bits 31:28.
- R11: `pc_load` and `lr_wr` are one-cycle strobes raised only by an entry, one entry per clock. An entry in the same cycle as a return or a status write wins, and the other request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, the reset exception |
| req_und | input | 1 | Undefined-instruction request |
| req_swi | input | 1 | Software-interrupt request |
| req_pabt | input | 1 | Instruction-fetch abort request |
| req_dabt | input | 1 | Data abort request |
| irq | input | 1 | Normal interrupt request |
| fiq | input | 1 | Fast interrupt request |
| fault_addr | input | XLEN | Address of the instruction that raised a synchronous exception |
| pc_now | input | XLEN | Current PC value used for interrupt link values |
| ret_req | input | 1 | Exception return: restore saved status |
| st_wr | input | 1 | Status word write strobe |
| st_wdata | input | XLEN | Status word write data |
| pc_load | output | 1 | One-cycle PC redirect strobe |
| pc_target | output | XLEN | Vector address for the redirect |
| lr_wr | output | 1 | One-cycle link register write strobe |
| lr_value | output | XLEN | Link value to write |
| lr_mode | output | 5 | Mode whose link register is written |
| cur_status | output | XLEN | Current status word |
| cur_saved | output | XLEN | Saved status word of the current mode |
| illegal_mode | output | 1 | One-cycle pulse: rejected mode field |

## Verification
A corrupted status word shows on `cur_status` in the cycle right after the edge that wrote it. A wrong mask bit shows up one cycle later, as an interrupt taken or refused against the requirement. A wrong saved word stays hidden until the handler returns. Each entry is therefore followed by a return, so that a bank written at the wrong index or with the wrong value reaches `cur_status` within two cycles. The priority chain is exercised by removing the winner one request at a time, so a swapped rank shows up as a wrong vector on the first strobe.

// File: rtl/xcpt_pkg.sv
package xcpt_pkg;

  typedef enum logic [4:0] {
    M_USR = 5'b10000,
    M_FIQ = 5'b10001,
    M_IRQ = 5'b10010,
    M_SVC = 5'b10011,
    M_ABT = 5'b10111,
    M_UND = 5'b11011,
    M_SYS = 5'b11111
  } mode_e;

  // Index doubles as vector slot: vector = index * 4.
  typedef enum logic [2:0] {
    X_RST  = 3'd0,
    X_UND  = 3'd1,
    X_SWI  = 3'd2,
    X_PABT = 3'd3,
    X_DABT = 3'd4,
    X_RSV  = 3'd5,
    X_IRQ  = 3'd6,
    X_FIQ  = 3'd7
  } xcpt_e;

  localparam int unsigned BIT_I = 7;
  localparam int unsigned BIT_F = 6;
  localparam int unsigned BIT_T = 5;
  localparam int unsigned NBANK = 5;
  localparam int unsigned BANK_W = $clog2(NBANK);

  function automatic logic mode_legal(input logic [4:0] m);
    case (m)
      M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS: mode_legal = 1'b1;
      default:                                         mode_legal = 1'b0;
    endcase
  endfunction

  function automatic logic mode_banked(input logic [4:0] m);
    case (m)
      M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND: mode_banked = 1'b1;
      default:                           mode_banked = 1'b0;
    endcase
  endfunction

  function automatic logic [BANK_W-1:0] bank_of(input logic [4:0] m);
    case (m)
      M_FIQ:   bank_of = BANK_W'(0);
      M_IRQ:   bank_of = BANK_W'(1);
      M_SVC:   bank_of = BANK_W'(2);
      M_ABT:   bank_of = BANK_W'(3);
      default: bank_of = BANK_W'(4);
    endcase
  endfunction

endpackage

// File: rtl/xcpt_arbiter.sv
module xcpt_arbiter
  import xcpt_pkg::*;
(
  input  logic  req_und,
  input  logic  req_swi,
  input  logic  req_pabt,
  input  logic  req_dabt,
  input  logic  irq,
  input  logic  fiq,
  input  logic  mask_i,
  input  logic  mask_f,
  output logic  take,
  output xcpt_e kind
);

  logic irq_ok, fiq_ok;

  assign irq_ok = irq & ~mask_i;
  assign fiq_ok = fiq & ~mask_f;

  always_comb begin
    take = 1'b1;
    kind = X_RSV;
    if (req_dabt)      kind = X_DABT;
    else if (fiq_ok)   kind = X_FIQ;
    else if (irq_ok)   kind = X_IRQ;
    else if (req_pabt) kind = X_PABT;
    else if (req_und)  kind = X_UND;
    else if (req_swi)  kind = X_SWI;
    else               take = 1'b0;
  end

endmodule

// File: rtl/xcpt_entry_calc.sv
module xcpt_entry_calc
  import xcpt_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned SLOT_BYTES = 4
) (
  input  xcpt_e            kind,
  input  logic [XLEN-1:0]  fault_addr,
  input  logic [XLEN-1:0]  pc_now,
  input  logic [XLEN-1:0]  status,
  output logic [XLEN-1:0]  vector,
  output logic [4:0]       new_mode,
  output logic [XLEN-1:0]  link,
  output logic [XLEN-1:0]  new_status
);

  localparam logic [XLEN-1:0] OFS_SYNC = XLEN'(4);
  localparam logic [XLEN-1:0] OFS_DATA = XLEN'(8);
  localparam logic [XLEN-1:0] OFS_INT  = XLEN'(4);

  assign vector = XLEN'(kind) * XLEN'(SLOT_BYTES);

  always_comb begin
    new_mode = M_SVC;
    link     = fault_addr + OFS_SYNC;
    case (kind)
      X_UND:  new_mode = M_UND;
      X_SWI:  new_mode = M_SVC;
      X_PABT: new_mode = M_ABT;
      X_DABT: begin
        new_mode = M_ABT;
        link     = fault_addr + OFS_DATA;
      end
      X_IRQ: begin
        new_mode = M_IRQ;
        link     = pc_now - OFS_INT;
      end
      X_FIQ: begin
        new_mode = M_FIQ;
        link     = pc_now - OFS_INT;
      end
      default: new_mode = M_SVC;
    endcase
  end

  always_comb begin
    new_status        = status;
    new_status[BIT_I] = 1'b1;
    new_status[BIT_F] = status[BIT_F] | (kind == X_FIQ);
    new_status[BIT_T] = 1'b0;
    new_status[4:0]   = new_mode;
  end

endmodule

// File: rtl/xcpt_saved_bank.sv
module xcpt_saved_bank
  import xcpt_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [BANK_W-1:0] widx,
  input  logic [XLEN-1:0]   wdata,
  input  logic [BANK_W-1:0] ridx,
  output logic [XLEN-1:0]   rdata
);

  logic [XLEN-1:0] slot [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                            slot[g] <= '0;
      else if (we && widx == BANK_W'(g))  slot[g] <= wdata;
    end
  end

  assign rdata = slot[ridx];

endmodule

// File: rtl/xcpt_mode_ctrl.sv
module xcpt_mode_ctrl
  import xcpt_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_und,
  input  logic            req_swi,
  input  logic            req_pabt,
  input  logic            req_dabt,
  input  logic            irq,
  input  logic            fiq,
  input  logic [XLEN-1:0] fault_addr,
  input  logic [XLEN-1:0] pc_now,
  input  logic            ret_req,
  input  logic            st_wr,
  input  logic [XLEN-1:0] st_wdata,
  output logic            pc_load,
  output logic [XLEN-1:0] pc_target,
  output logic            lr_wr,
  output logic [XLEN-1:0] lr_value,
  output logic [4:0]      lr_mode,
  output logic [XLEN-1:0] cur_status,
  output logic [XLEN-1:0] cur_saved,
  output logic            illegal_mode
);

  localparam logic [XLEN-1:0] RST_STATUS =
    XLEN'((1 << BIT_I) | (1 << BIT_F) | int'(M_SVC));

  logic            take;
  xcpt_e           kind;
  logic [XLEN-1:0] vec, link, nstat, saved_rd;
  logic [4:0]      nmode;
  logic            in_bank, in_user;

  assign in_bank = mode_banked(cur_status[4:0]);
  assign in_user = (cur_status[4:0] == M_USR);

  xcpt_arbiter u_arb (
    .req_und (req_und),
    .req_swi (req_swi),
    .req_pabt(req_pabt),
    .req_dabt(req_dabt),
    .irq     (irq),
    .fiq     (fiq),
    .mask_i  (cur_status[BIT_I]),
    .mask_f  (cur_status[BIT_F]),
    .take    (take),
    .kind    (kind)
  );

  xcpt_entry_calc #(.XLEN(XLEN)) u_calc (
    .kind      (kind),
    .fault_addr(fault_addr),
    .pc_now    (pc_now),
    .status    (cur_status),
    .vector    (vec),
    .new_mode  (nmode),
    .link      (link),
    .new_status(nstat)
  );

  xcpt_saved_bank #(.XLEN(XLEN)) u_bank (
    .clk  (clk),
    .rst  (rst),
    .we   (take),
    .widx (bank_of(nmode)),
    .wdata(cur_status),
    .ridx (bank_of(cur_status[4:0])),
    .rdata(saved_rd)
  );

  assign cur_saved = in_bank ? saved_rd : '0;

  // Candidate for a return or a software write, before the mode check.
  logic            upd_en;
  logic [XLEN-1:0] upd_val;

  always_comb begin
    upd_en  = 1'b0;
    upd_val = st_wdata;
    if (ret_req && in_bank) begin
      upd_en  = 1'b1;
      upd_val = saved_rd;
    end else if (st_wr) begin
      upd_en  = 1'b1;
      upd_val = in_user ? {st_wdata[XLEN-1:XLEN-4], cur_status[XLEN-5:0]}
                        : st_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_status   <= RST_STATUS;
      pc_load      <= 1'b1;
      pc_target    <= '0;
      lr_wr        <= 1'b0;
      lr_value     <= '0;
      lr_mode      <= M_SVC;
      illegal_mode <= 1'b0;
    end else begin
      pc_load      <= 1'b0;
      lr_wr        <= 1'b0;
      illegal_mode <= 1'b0;
      if (take) begin
        cur_status <= nstat;
        pc_load    <= 1'b1;
        pc_target  <= vec;
        lr_wr      <= 1'b1;
        lr_value   <= link;
        lr_mode    <= nmode;
      end else if (upd_en) begin
        if (mode_legal(upd_val[4:0])) begin
          cur_status <= upd_val;
        end else begin
          cur_status   <= {upd_val[XLEN-1:5], cur_status[4:0]};
          illegal_mode <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/xcpt_mode_ctrl_chk.sv
module xcpt_mode_ctrl_chk
  import xcpt_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            pc_load,
  input logic [XLEN-1:0] pc_target,
  input logic            lr_wr,
  input logic [XLEN-1:0] cur_status,
  input logic            illegal_mode
);

  localparam logic [XLEN-1:0] V_IRQ = XLEN'(32'h18);
  localparam logic [XLEN-1:0] V_FIQ = XLEN'(32'h1C);
  localparam logic [XLEN-1:0] V_RSV = XLEN'(32'h14);

  // R9: the mode field never holds an illegal encoding
  assert_mode_legal_R9: assert property (@(posedge clk) disable iff (rst)
    mode_legal(cur_status[4:0]));

  // R4: a redirect always lands with I set and T clear
  assert_entry_masks_R4: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> (cur_status[BIT_I] && !cur_status[BIT_T]));

  // R4: FIQ entry leaves F set
  assert_fiq_sets_f_R4: assert property (@(posedge clk) disable iff (rst)
    (pc_load && pc_target == V_FIQ) |-> cur_status[BIT_F]);

  // R6: IRQ taken only when I was clear beforehand
  assert_irq_masked_R6: assert property (@(posedge clk) disable iff (rst)
    (pc_load && pc_target == V_IRQ) |-> !$past(cur_status[BIT_I]));

  // R6: FIQ taken only when F was clear beforehand
  assert_fiq_masked_R6: assert property (@(posedge clk) disable iff (rst)
    (pc_load && pc_target == V_FIQ) |-> !$past(cur_status[BIT_F]));

  // R11: every non-reset redirect writes the link and vice versa
  assert_link_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    (pc_load && pc_target != '0) |-> lr_wr);
  assert_link_only_entry_R11: assert property (@(posedge clk) disable iff (rst)
    lr_wr |-> pc_load);

  // R2: reserved vector never used
  assert_no_rsv_vector_R2: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> pc_target != V_RSV);

  // R9: a rejected mode leaves the mode field unchanged
  assert_illegal_keeps_mode_R9: assert property (@(posedge clk) disable iff (rst)
    illegal_mode |-> $stable(cur_status[4:0]));

endmodule

bind xcpt_mode_ctrl xcpt_mode_ctrl_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pc_load     (pc_load),
  .pc_target   (pc_target),
  .lr_wr       (lr_wr),
  .cur_status  (cur_status),
  .illegal_mode(illegal_mode)
);

// File: tb/tb_xcpt_mode_ctrl.sv
`timescale 1ns/1ps
module tb_xcpt_mode_ctrl;

  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_und = 0, req_swi = 0, req_pabt = 0, req_dabt = 0, irq = 0, fiq = 0;
  logic [XLEN-1:0] fault_addr = '0, pc_now = '0, st_wdata = '0;
  logic ret_req = 0, st_wr = 0;
  logic            pc_load, lr_wr, illegal_mode;
  logic [XLEN-1:0] pc_target, lr_value, cur_status, cur_saved;
  logic [4:0]      lr_mode;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  xcpt_mode_ctrl #(.XLEN(XLEN)) dut (
    .clk(clk), .rst(rst),
    .req_und(req_und), .req_swi(req_swi), .req_pabt(req_pabt),
    .req_dabt(req_dabt), .irq(irq), .fiq(fiq),
    .fault_addr(fault_addr), .pc_now(pc_now),
    .ret_req(ret_req), .st_wr(st_wr), .st_wdata(st_wdata),
    .pc_load(pc_load), .pc_target(pc_target),
    .lr_wr(lr_wr), .lr_value(lr_value), .lr_mode(lr_mode),
    .cur_status(cur_status), .cur_saved(cur_saved),
    .illegal_mode(illegal_mode)
  );

  task automatic chk(input string tag, input logic [XLEN-1:0] act,
                     input logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic clear_inputs();
    req_und = 0; req_swi = 0; req_pabt = 0; req_dabt = 0;
    irq = 0; fiq = 0; ret_req = 0; st_wr = 0;
  endtask

  // Inputs are applied at the falling edge, results read 1 ns after the rise.
  task automatic edge_then_look();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_cycle(input string tag);
    @(negedge clk);
    clear_inputs();
    edge_then_look();
    chk({tag, " R11 pc_load drops"}, XLEN'(pc_load), 0);
    chk({tag, " R11 lr_wr drops"}, XLEN'(lr_wr), 0);
  endtask

  task automatic write_status(input logic [XLEN-1:0] v, input logic [XLEN-1:0] exp,
                              input logic exp_ill, input string tag);
    @(negedge clk);
    clear_inputs();
    st_wr = 1; st_wdata = v;
    edge_then_look();
    chk({tag, " status"}, cur_status, exp);
    chk({tag, " illegal flag"}, XLEN'(illegal_mode), XLEN'(exp_ill));
    idle_cycle(tag);
    chk({tag, " R9 illegal pulse ends"}, XLEN'(illegal_mode), 0);
  endtask

  task automatic do_return(input logic [XLEN-1:0] exp, input string tag);
    @(negedge clk);
    clear_inputs();
    ret_req = 1;
    edge_then_look();
    chk({tag, " R8 restored status"}, cur_status, exp);
    chk({tag, " R11 no redirect on return"}, XLEN'(pc_load), 0);
    idle_cycle(tag);
  endtask

  // Drive a request set; check the resulting entry.
  task automatic entry(input logic [5:0] rq, input logic [XLEN-1:0] exp_vec,
                       input logic [XLEN-1:0] exp_lr, input logic [4:0] exp_mode,
                       input logic [XLEN-1:0] exp_stat, input logic [XLEN-1:0] exp_saved,
                       input string tag);
    @(negedge clk);
    clear_inputs();
    {req_dabt, fiq, irq, req_pabt, req_und, req_swi} = rq;
    edge_then_look();
    chk({tag, " R11 pc_load"}, XLEN'(pc_load), 1);
    chk({tag, " R2 vector"}, pc_target, exp_vec);
    chk({tag, " R3 link"}, lr_value, exp_lr);
    chk({tag, " R3 link mode"}, XLEN'(lr_mode), XLEN'(exp_mode));
    chk({tag, " R11 lr_wr"}, XLEN'(lr_wr), 1);
    chk({tag, " R4 status"}, cur_status, exp_stat);
    chk({tag, " R5 saved"}, cur_saved, exp_saved);
    idle_cycle(tag);
  endtask

  task automatic blocked(input logic [5:0] rq, input logic [XLEN-1:0] exp_stat,
                         input string tag);
    @(negedge clk);
    clear_inputs();
    {req_dabt, fiq, irq, req_pabt, req_und, req_swi} = rq;
    edge_then_look();
    chk({tag, " R6 no entry"}, XLEN'(pc_load), 0);
    chk({tag, " R6 status kept"}, cur_status, exp_stat);
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset status", cur_status, 32'h0000_00D3);
    chk("R1 reset pc_load", XLEN'(pc_load), 1);
    chk("R1 reset vector", pc_target, 0);
    chk("R1 reset lr_wr", XLEN'(lr_wr), 0);
    @(negedge clk);
    rst = 0;
    edge_then_look();
    chk("R1 strobe ends after reset", XLEN'(pc_load), 0);
  endtask

  task automatic t_interrupts();
    pc_now = 32'h0000_1000;
    write_status(32'hA000_001F, 32'hA000_001F, 0, "R9 write sys");
    entry(6'b001000, 32'h18, 32'h0000_0FFC, 5'b10010, 32'hA000_0092, 32'hA000_001F, "irq");
    blocked(6'b001000, 32'hA000_0092, "irq while I set");
    do_return(32'hA000_001F, "irq return");
    pc_now = 32'h0000_2468;
    entry(6'b010000, 32'h1C, 32'h0000_2464, 5'b10001, 32'hA000_00D1, 32'hA000_001F, "fiq");
    blocked(6'b011000, 32'hA000_00D1, "fiq/irq while masked");
    do_return(32'hA000_001F, "fiq return");
    write_status(32'h0000_005F, 32'h0000_005F, 0, "R6 set F");
    entry(6'b011000, 32'h18, 32'h0000_2464, 5'b10010, 32'h0000_00D2, 32'h0000_005F,
          "R6 fiq masked irq wins");
    do_return(32'h0000_005F, "R6 return");
    write_status(32'h0000_003F, 32'h0000_003F, 0, "R4 set T");
    entry(6'b001000, 32'h18, 32'h0000_2464, 5'b10010, 32'h0000_0092, 32'h0000_003F,
          "R4 T cleared");
    do_return(32'h0000_003F, "R8 T restored");
  endtask

  task automatic t_sync();
    fault_addr = 32'h0000_2000;
    write_status(32'h0000_001F, 32'h0000_001F, 0, "sync setup");
    entry(6'b000010, 32'h04, 32'h2004, 5'b11011, 32'h9B, 32'h1F, "undef");
    do_return(32'h1F, "undef return");
    entry(6'b000001, 32'h08, 32'h2004, 5'b10011, 32'h93, 32'h1F, "swi");
    do_return(32'h1F, "swi return");
    entry(6'b000100, 32'h0C, 32'h2004, 5'b10111, 32'h97, 32'h1F, "pabt");
    do_return(32'h1F, "pabt return");
    entry(6'b100000, 32'h10, 32'h2008, 5'b10111, 32'h97, 32'h1F, "dabt");
    do_return(32'h1F, "dabt return");
  endtask

  task automatic t_priority();
    pc_now = 32'h0000_3000;
    entry(6'b111111, 32'h10, 32'h2008, 5'b10111, 32'h97, 32'h1F, "R7 dabt top");
    do_return(32'h1F, "R7 ret1");
    entry(6'b011111, 32'h1C, 32'h2FFC, 5'b10001, 32'hD1, 32'h1F, "R7 fiq next");
    do_return(32'h1F, "R7 ret2");
    entry(6'b001111, 32'h18, 32'h2FFC, 5'b10010, 32'h92, 32'h1F, "R7 irq next");
    do_return(32'h1F, "R7 ret3");
    entry(6'b000111, 32'h0C, 32'h2004, 5'b10111, 32'h97, 32'h1F, "R7 pabt next");
    do_return(32'h1F, "R7 ret4");
    entry(6'b000011, 32'h04, 32'h2004, 5'b11011, 32'h9B, 32'h1F, "R7 undef over swi");
    do_return(32'h1F, "R7 ret5");
  endtask

  task automatic t_collisions();
    // R11: entry beats a status write in the same cycle
    @(negedge clk);
    clear_inputs();
    req_und = 1; st_wr = 1; st_wdata = 32'h0000_0013;
    edge_then_look();
    chk("R11 entry over write vector", pc_target, 32'h04);
    chk("R11 entry over write status", cur_status, 32'h9B);
    idle_cycle("R11 collision");
    do_return(32'h1F, "R11 collision return");
    // R11: entry beats a return in the same cycle (return is a no-op in sys anyway)
    @(negedge clk);
    clear_inputs();
    req_swi = 1; ret_req = 1;
    edge_then_look();
    chk("R11 entry over return status", cur_status, 32'h93);
    idle_cycle("R11 collision2");
    do_return(32'h1F, "R11 collision2 return");
  endtask

  task automatic t_modes();
    write_status(32'hF000_0005, 32'hF000_001F, 1, "R9 illegal mode");
    write_status(32'h0000_0010, 32'h0000_0010, 0, "R9 enter user");
    chk("R5 no saved word in user", cur_saved, 0);
    write_status(32'h5000_00DF, 32'h5000_0010, 0, "R10 user write flags only");
    do_return(32'h5000_0010, "R8 return ignored in user");
    fault_addr = 32'h0000_4000;
    entry(6'b000001, 32'h08, 32'h4004, 5'b10011, 32'h5000_0093, 32'h5000_0010,
          "swi from user");
    do_return(32'h5000_0010, "R8 back to user");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    t_reset();
    t_interrupts();
    t_sync();
    t_priority();
    t_collisions();
    t_modes();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule